// File: doc/BRIEF.md
# Step Sequencing and Miss Stall Controller

This block sequences a single-issue core. Each cycle in the running state it fetches the word at the program counter, executes it, and moves the program counter on. When the instruction cache reports a miss, the controller waits for the fill. It then executes the instruction it already holds and does not fetch it again. When the data cache reports a miss on an executed step, the controller waits for that fill too. For a read it strobes a replay, so that the datapath can write back the loaded value.

A sampling switch-out request takes the core out of service. If a data miss is outstanding, the switch-out first waits for that miss to finish. In every other state it takes effect at once and cancels the step of that cycle. Activation and suspension requests move the core between idle and running. Two counters add up the cycles spent waiting on instruction fills and on data fills. A fill pulse that arrives while nothing is outstanding sets a sticky error flag.

Steps are grouped into ticks of up to WIDTH consecutive steps. A slot index shows the position of each step inside its tick.

Top module: `core_step_ctrl`

## Requirements
- R1: While reset is low and right after it, the state is Idle (code 0), pc_o equals RESET_PC, npc_o equals RESET_PC+4, both stall counters are 0, and fill_err_o, switched_ack_o, fetch_en_o, exec_o and replay_o are 0.
- R2: The state encodings are Idle=0, Running=1, IStall=2, IComp=3, DStall=4, DSwitch=5, SwitchedOut=6. activate_i moves Idle to Running and has no effect in any other state. suspend_i moves Running to Idle (unless switch_req_i is high) and has no effect in any other state.
- R3: In Running with no switch or suspend request, fetch_en_o is high and fetch_addr_o equals pc_o with its two low bits cleared. If imiss_i is low, exec_o is high in the same cycle. On an executed step with fault_i low, pc_o takes the old npc_o and npc_o grows by 4. With fault_i high, both hold.
- R4: In Running, imiss_i cancels execution, holds the program counter and enters IStall. fill_done_i in IStall enters IComp. IComp lasts one cycle, asserts exec_o with fetch_en_o low, and then goes to Running (or to DStall if dmiss_i is high and fault_i is low).
- R5: An executed step with dmiss_i high and fault_i low still advances the program counter and enters DStall. fill_done_i in DStall returns to Running, and replay_o is high in that cycle exactly when fill_is_read_i is high.
- R6: switch_req_i takes priority over every other request. In DStall it enters DSwitch, or goes straight to SwitchedOut if fill_done_i is also high. In Idle, Running, IStall and IComp it enters SwitchedOut at once, with no fetch and no execution in that cycle.
- R7: fill_done_i in DSwitch enters SwitchedOut, with replay_o set to fill_is_read_i. switched_ack_o is high for exactly the first cycle in SwitchedOut. SwitchedOut ignores all inputs until reset.
- R8: istall_cyc_o grows by 1 for every cycle spent in IStall. dstall_cyc_o grows by 1 for every cycle spent in DStall or DSwitch. Both wrap modulo 2^CW.
- R9: slot_o is the index of a step within its tick. It is 0 on a step that follows a cycle without a step into Running. It grows by 1 on each further consecutive step and returns to 0 after the step with index WIDTH-1.
- R10: fill_done_i in Idle or Running sets fill_err_o, which stays set until reset. The pulse alters neither the state nor the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate_i | input | 1 | Start request |
| suspend_i | input | 1 | Stop request (also halt and deallocate) |
| switch_req_i | input | 1 | Sampling switch-out request |
| imiss_i | input | 1 | Instruction fetch of this cycle missed |
| dmiss_i | input | 1 | Data access of this cycle's step missed |
| fault_i | input | 1 | Step of this cycle faulted |
| fill_done_i | input | 1 | Outstanding miss completed |
| fill_is_read_i | input | 1 | Completed data access was a read |
| state_o | output | 3 | Current state code |
| fetch_en_o | output | 1 | Fetch strobe |
| fetch_addr_o | output | AW | Word-aligned fetch address |
| exec_o | output | 1 | Execute strobe |
| replay_o | output | 1 | Re-execute strobe for a completed read miss |
| slot_o | output | SLOT_W | Step index inside the tick |
| pc_o | output | AW | Program counter |
| npc_o | output | AW | Next program counter |
| switched_ack_o | output | 1 | Switch-out acknowledge pulse |
| istall_cyc_o | output | CW | Instruction stall cycle total |
| dstall_cyc_o | output | CW | Data stall cycle total |
| fill_err_o | output | 1 | Sticky stray-fill flag |

## Verification
The bench builds the block with WIDTH=3, so the slot index has to wrap at a bound that is not a power of two. RESET_PC is 0x102, which has its low bits set, so the fetch address must show the masking while the program counter keeps its raw value. CW=8 lets long random runs of stalls carry both stall counters past their wrap point. AW=16 keeps the address arithmetic narrow, so the 4-byte increment is checked at a non-default width.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_ISTALL  = 3'd2,
    ST_ICOMP   = 3'd3,
    ST_DSTALL  = 3'd4,
    ST_DSWITCH = 3'd5,
    ST_OUT     = 3'd6
  } step_state_e;

  function automatic logic is_dwait(step_state_e s);
    return (s == ST_DSTALL) || (s == ST_DSWITCH);
  endfunction
endpackage

// File: rtl/stepctl_stallcnt.sv
module stepctl_stallcnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt_q
);
  function automatic logic [CW-1:0] bump(logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= bump(cnt_q);
  end
endmodule

// File: rtl/stepctl_pc.sv
module stepctl_pc #(
  parameter int unsigned    AW       = 32,
  parameter logic [AW-1:0]  RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] npc_q,
  output logic [AW-1:0] fetch_addr
);
  localparam logic [AW-1:0] STEP_BYTES = AW'(4);

  function automatic logic [AW-1:0] word_align(logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  function automatic logic [AW-1:0] seq_next(logic [AW-1:0] a);
    return a + STEP_BYTES;
  endfunction

  assign fetch_addr = word_align(pc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= seq_next(RESET_PC);
    end else if (advance) begin
      pc_q  <= npc_q;
      npc_q <= seq_next(npc_q);
    end
  end
endmodule

// File: rtl/stepctl_fsm.sv
module stepctl_fsm
  import stepctl_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              activate,
  input  logic              suspend,
  input  logic              switch_req,
  input  logic              imiss,
  input  logic              dmiss,
  input  logic              fault,
  input  logic              fill_done,
  input  logic              fill_is_read,
  output step_state_e       st_q,
  output logic              fetch_en,
  output logic              exec_stb,
  output logic              replay_stb,
  output logic              advance,
  output logic              ack_q,
  output logic              err_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              in_istall,
  output logic              in_dwait
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIDTH - 1);

  step_state_e       st_n;
  logic              stray_fill;
  logic [SLOT_W-1:0] slot_n;

  always_comb begin
    st_n       = st_q;
    fetch_en   = 1'b0;
    exec_stb   = 1'b0;
    replay_stb = 1'b0;
    stray_fill = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        stray_fill = fill_done;
        if (switch_req)    st_n = ST_OUT;
        else if (activate) st_n = ST_RUN;
      end
      ST_RUN: begin
        stray_fill = fill_done;
        if (switch_req)   st_n = ST_OUT;
        else if (suspend) st_n = ST_IDLE;
        else begin
          fetch_en = 1'b1;
          if (imiss) st_n = ST_ISTALL;
          else begin
            exec_stb = 1'b1;
            if (dmiss && !fault) st_n = ST_DSTALL;
          end
        end
      end
      ST_ISTALL: begin
        if (switch_req)     st_n = ST_OUT;
        else if (fill_done) st_n = ST_ICOMP;
      end
      ST_ICOMP: begin
        if (switch_req) st_n = ST_OUT;
        else begin
          exec_stb = 1'b1;
          st_n = (dmiss && !fault) ? ST_DSTALL : ST_RUN;
        end
      end
      ST_DSTALL: begin
        replay_stb = fill_done && fill_is_read;
        if (switch_req)     st_n = fill_done ? ST_OUT : ST_DSWITCH;
        else if (fill_done) st_n = ST_RUN;
      end
      ST_DSWITCH: begin
        if (fill_done) begin
          replay_stb = fill_is_read;
          st_n = ST_OUT;
        end
      end
      default: ;
    endcase
  end

  assign advance   = exec_stb && !fault;
  assign in_istall = (st_q == ST_ISTALL);
  assign in_dwait  = is_dwait(st_q);
  assign slot_n    = (exec_stb && st_n == ST_RUN && slot_q != LAST_SLOT)
                     ? slot_q + SLOT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      st_q   <= st_n;
      ack_q  <= (st_n == ST_OUT) && (st_q != ST_OUT);
      err_q  <= err_q | stray_fill;
      slot_q <= slot_n;
    end
  end
endmodule

// File: rtl/core_step_ctrl.sv
module core_step_ctrl
  import stepctl_pkg::*;
#(
  parameter int unsigned   WIDTH    = 4,
  parameter int unsigned   AW       = 32,
  parameter int unsigned   CW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int unsigned  SLOT_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              activate_i,
  input  logic              suspend_i,
  input  logic              switch_req_i,
  input  logic              imiss_i,
  input  logic              dmiss_i,
  input  logic              fault_i,
  input  logic              fill_done_i,
  input  logic              fill_is_read_i,
  output logic [2:0]        state_o,
  output logic              fetch_en_o,
  output logic [AW-1:0]     fetch_addr_o,
  output logic              exec_o,
  output logic              replay_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     npc_o,
  output logic              switched_ack_o,
  output logic [CW-1:0]     istall_cyc_o,
  output logic [CW-1:0]     dstall_cyc_o,
  output logic              fill_err_o
);
  step_state_e st;
  logic        advance;
  logic        in_istall;
  logic        in_dwait;

  stepctl_fsm #(.WIDTH(WIDTH), .SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .activate(activate_i), .suspend(suspend_i), .switch_req(switch_req_i),
    .imiss(imiss_i), .dmiss(dmiss_i), .fault(fault_i),
    .fill_done(fill_done_i), .fill_is_read(fill_is_read_i),
    .st_q(st), .fetch_en(fetch_en_o), .exec_stb(exec_o),
    .replay_stb(replay_o), .advance(advance), .ack_q(switched_ack_o),
    .err_q(fill_err_o), .slot_q(slot_o),
    .in_istall(in_istall), .in_dwait(in_dwait)
  );

  stepctl_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .pc_q(pc_o), .npc_q(npc_o), .fetch_addr(fetch_addr_o)
  );

  stepctl_stallcnt #(.CW(CW)) u_icnt (
    .clk(clk), .rst_n(rst_n), .en(in_istall), .cnt_q(istall_cyc_o)
  );

  stepctl_stallcnt #(.CW(CW)) u_dcnt (
    .clk(clk), .rst_n(rst_n), .en(in_dwait), .cnt_q(dstall_cyc_o)
  );

  assign state_o = st;
endmodule

// File: rtl/stepctl_chk.sv
module stepctl_chk #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned AW     = 32,
  parameter int unsigned CW     = 16,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              activate_i,
  input logic              switch_req_i,
  input logic              fault_i,
  input logic              fill_done_i,
  input logic              fill_is_read_i,
  input logic [2:0]        state_o,
  input logic              fetch_en_o,
  input logic              exec_o,
  input logic              replay_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic [AW-1:0]     pc_o,
  input logic [AW-1:0]     npc_o,
  input logic              switched_ack_o,
  input logic [CW-1:0]     istall_cyc_o,
  input logic [CW-1:0]     dstall_cyc_o,
  input logic              fill_err_o
);
  p_activate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && activate_i && !switch_req_i) |=> state_o == 3'd1);

  p_fetch_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |-> state_o == 3'd1);

  p_pc_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !fault_i) |=> pc_o == $past(npc_o));

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |=> $stable(pc_o));

  p_icomp_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |=> state_o != 3'd3);

  p_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay_o |-> (fill_done_i && fill_is_read_i &&
                  (state_o == 3'd4 || state_o == 3'd5)));

  p_out_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |=> state_o == 3'd6);

  p_ack_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    switched_ack_o |-> (state_o == 3'd6 && $past(state_o) != 3'd6));

  p_icnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |=> istall_cyc_o == $past(istall_cyc_o) + CW'(1));

  p_dcnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 || state_o == 3'd5) |=>
      dstall_cyc_o == $past(dstall_cyc_o) + CW'(1));

  p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot_o) < WIDTH);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err_o |=> fill_err_o);
endmodule

bind core_step_ctrl stepctl_chk #(
  .WIDTH(WIDTH), .AW(AW), .CW(CW), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .activate_i(activate_i),
  .switch_req_i(switch_req_i), .fault_i(fault_i),
  .fill_done_i(fill_done_i), .fill_is_read_i(fill_is_read_i),
  .state_o(state_o), .fetch_en_o(fetch_en_o), .exec_o(exec_o),
  .replay_o(replay_o), .slot_o(slot_o), .pc_o(pc_o), .npc_o(npc_o),
  .switched_ack_o(switched_ack_o), .istall_cyc_o(istall_cyc_o),
  .dstall_cyc_o(dstall_cyc_o), .fill_err_o(fill_err_o)
);

// File: tb/sim_core_step_ctrl.sv
module sim_core_step_ctrl;
  localparam int unsigned W  = 3;
  localparam int unsigned AW = 16;
  localparam int unsigned CW = 8;
  localparam logic [15:0] RPC = 16'h0102;
  localparam int unsigned SW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, act, sus, swr, im, dm, flt, fd, fr;
  logic [2:0]    state_o;
  logic          fetch_en_o, exec_o, replay_o, ack_o, err_o;
  logic [AW-1:0] fetch_addr_o, pc_o, npc_o;
  logic [SW-1:0] slot_o;
  logic [CW-1:0] icnt_o, dcnt_o;

  core_step_ctrl #(.WIDTH(W), .AW(AW), .CW(CW), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .suspend_i(sus),
    .switch_req_i(swr), .imiss_i(im), .dmiss_i(dm), .fault_i(flt),
    .fill_done_i(fd), .fill_is_read_i(fr), .state_o(state_o),
    .fetch_en_o(fetch_en_o), .fetch_addr_o(fetch_addr_o), .exec_o(exec_o),
    .replay_o(replay_o), .slot_o(slot_o), .pc_o(pc_o), .npc_o(npc_o),
    .switched_ack_o(ack_o), .istall_cyc_o(icnt_o), .dstall_cyc_o(dcnt_o),
    .fill_err_o(err_o)
  );

  int checks = 0;
  int errors = 0;

  // reference state of the bench
  int          m_st;
  logic [15:0] m_pc, m_npc;
  int          m_ic, m_dc, m_slot;
  bit          m_err, m_ack;

  task automatic chk(string tag, string what, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  function automatic logic [15:0] plus4(logic [15:0] a);
    return 16'(a + 16'd4);
  endfunction

  task automatic model_reset();
    m_st = 0; m_pc = RPC; m_npc = plus4(RPC);
    m_ic = 0; m_dc = 0; m_slot = 0; m_err = 0; m_ack = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0; act = 0; sus = 0; swr = 0; im = 0; dm = 0; flt = 0; fd = 0; fr = 0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    // R1 reset values
    chk("R1", "state", 64'(state_o), 64'd0);
    chk("R1", "pc", 64'(pc_o), 64'(RPC));
    chk("R1", "npc", 64'(npc_o), 64'(plus4(RPC)));
    chk("R1", "icnt", 64'(icnt_o), 64'd0);
    chk("R1", "dcnt", 64'(dcnt_o), 64'd0);
    chk("R1", "flags", 64'({err_o, ack_o, fetch_en_o, exec_o, replay_o}), 64'd0);
    rst_n = 1;
  endtask

  task automatic cyc(bit a, bit s, bit w, bit i, bit d, bit f, bit c, bit r);
    int  nst;
    bit  ef, ee, er, bad;
    @(negedge clk);
    act = a; sus = s; swr = w; im = i; dm = d; flt = f; fd = c; fr = r;
    #1;
    nst = m_st; ef = 0; ee = 0; er = 0; bad = 0;
    if (m_st == 0) begin
      bad = c;
      if (w) nst = 6; else if (a) nst = 1;
    end else if (m_st == 1) begin
      bad = c;
      if (w) nst = 6;
      else if (s) nst = 0;
      else begin
        ef = 1;
        if (i) nst = 2;
        else begin ee = 1; if (d && !f) nst = 4; end
      end
    end else if (m_st == 2) begin
      if (w) nst = 6; else if (c) nst = 3;
    end else if (m_st == 3) begin
      if (w) nst = 6;
      else begin ee = 1; nst = (d && !f) ? 4 : 1; end
    end else if (m_st == 4) begin
      er = c && r;
      if (w) nst = c ? 6 : 5; else if (c) nst = 1;
    end else if (m_st == 5) begin
      if (c) begin er = r; nst = 6; end
    end
    chk("R2 R6", "state", 64'(state_o), 64'(m_st));
    chk("R3 R4", "fetch_en", 64'(fetch_en_o), 64'(ef));
    if (ef) chk("R3", "fetch_addr", 64'(fetch_addr_o), 64'(m_pc & 16'hfffc));
    chk("R4 R5", "exec", 64'(exec_o), 64'(ee));
    chk("R5 R7", "replay", 64'(replay_o), 64'(er));
    chk("R3", "pc", 64'(pc_o), 64'(m_pc));
    chk("R3", "npc", 64'(npc_o), 64'(m_npc));
    chk("R7", "ack", 64'(ack_o), 64'(m_ack));
    chk("R8", "icnt", 64'(icnt_o), 64'(m_ic));
    chk("R8", "dcnt", 64'(dcnt_o), 64'(m_dc));
    chk("R9", "slot", 64'(slot_o), 64'(m_slot));
    chk("R10", "err", 64'(err_o), 64'(m_err));
    // advance the reference to the post-edge values
    if (m_st == 2) m_ic = (m_ic + 1) % (1 << CW);
    if (m_st == 4 || m_st == 5) m_dc = (m_dc + 1) % (1 << CW);
    if (ee && !f) begin m_pc = m_npc; m_npc = plus4(m_npc); end
    m_ack  = (nst == 6) && (m_st != 6);
    m_err  = m_err | bad;
    m_slot = (ee && nst == 1 && m_slot != W - 1) ? m_slot + 1 : 0;
    m_st   = nst;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int outc;
    void'($urandom(32'd4242));
    apply_reset();
    // R2: suspend in Idle ignored, activate starts
    cyc(0,1,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0);             // activate in Running ignored
    // R3 R9: consecutive steps, slot wraps at 3
    for (int k = 0; k < 5; k++) cyc(0,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,1,0,0);             // R3 faulted step holds pc
    // R4 R8: icache miss, three waiting cycles then fill
    cyc(0,0,0,1,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0);
    cyc(0,1,0,0,0,0,0,0);             // suspend ignored in IStall
    cyc(0,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,0);             // IComp: exec without fetch
    cyc(0,0,0,0,0,0,0,0);
    // R5: data read miss with replay, then a write miss
    cyc(0,0,0,0,1,0,0,0);
    cyc(0,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,1,1);
    cyc(0,0,0,0,1,0,0,0);
    cyc(0,0,0,0,0,0,1,0);
    // R10: stray fill in Running
    cyc(0,0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0,0);
    // R6 R7: switch during data miss waits, then acknowledge
    cyc(0,0,0,0,1,0,0,0);
    cyc(0,0,1,0,0,0,0,0);
    cyc(0,0,1,0,0,0,0,0);
    cyc(0,0,0,0,0,0,1,1);
    cyc(1,0,0,0,0,0,1,1);             // ignored in SwitchedOut
    cyc(0,0,0,0,0,0,0,0);
    // R6: switch in Running cancels the step
    apply_reset();
    cyc(1,0,0,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0);
    cyc(0,1,1,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0);
    // R6: switch in Idle, and switch with fill together in DStall
    apply_reset();
    cyc(0,0,1,0,0,0,0,0);
    cyc(0,0,0,0,0,0,0,0);
    apply_reset();
    cyc(1,0,0,0,0,0,0,0);
    cyc(0,0,0,0,1,0,0,0);
    cyc(0,0,1,0,0,0,1,1);
    cyc(0,0,0,0,0,0,0,0);
    // random phase
    apply_reset();
    outc = 0;
    for (int n = 0; n < 4000; n++) begin
      bit c;
      if (m_st == 2 || m_st == 4 || m_st == 5) c = ($urandom % 4) == 0;
      else c = ($urandom % 40) == 0;
      cyc(($urandom % 8) == 0, ($urandom % 20) == 0, ($urandom % 150) == 0,
          ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 10) == 0,
          c, 1'($urandom % 2));
      if (m_st == 6) begin
        outc++;
        if (outc > 4) begin apply_reset(); outc = 0; end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule